// File: doc/BRIEF.md
# Buffer Select Data Alignment Network

This block sits between a set of M word buffers, each filled bit by bit from its own serial link, and a pipelined operator that consumes one parallel word per transfer. Words are never reordered while they travel. Instead, a one-hot select vector picks the buffer that drives the shared output word on each transfer. The select sequence comes from one of three generators, so a single network handles three storage layouts.

In stride-1 mode a single rotating shift register walks the select bit across the buffers. In skewed mode two shift registers behave as nested loops: an outer register holds the starting buffer of the current row, and an inner register walks across the row. In scrambled mode the select words are taken from a small FIFO that software or an address generator fills beforehand. A run starts with a start pulse, a mode code and an element count. The output side is a valid/ready stream. The order FIFO is loaded through its own valid/ready port, and `ord_ready` is low only when the FIFO is full.

Top module: `ad_align_net`

## Requirements
- R1: After reset, `out_valid`, `done` and `err` are low and `ord_ready` is high.
- R2: Each pulse of `ser_shift` shifts `ser_in[i]` into the least significant bit of buffer i, so after W pulses given most significant bit first, buffer i holds the whole word.
- R3: A start pulse is accepted only when no run is active, `mode` is 00, 01 or 10, and `count` is nonzero. Any other start is ignored: no output appears and `done` keeps its value.
- R4: With mode 00 (stride-1), element k of the run comes from buffer k mod M, so the first element comes from buffer 0.
- R5: With mode 01 (skewed), element k comes from buffer (floor(k/M) + k mod M) mod M.
- R6: With mode 10 (scrambled), element k comes from the buffer whose bit is set in the k-th FIFO entry. Bit i of an entry selects buffer i.
- R7: An element is consumed only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged, provided the buffers are not shifted.
- R8: In scrambled mode, `out_valid` stays low while the order FIFO is empty, and the run resumes once an entry arrives.
- R9: The order FIFO holds DEPTH entries. An entry is stored on a cycle where `ord_valid` and `ord_ready` are both high, and `ord_ready` is low exactly when the FIFO is full. A push and a pop may occur in the same cycle.
- R10: A FIFO entry that is not one-hot produces an all-zero output word and still counts as an element. `err` rises in the cycle after that element is consumed and stays high until the next accepted start.
- R11: One cycle after the count-th element is consumed, `done` is high and `out_valid` is low. `done` stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_shift | input | 1 | Shift all buffers by one bit |
| ser_in | input | M | One serial bit per buffer |
| start | input | 1 | Run start pulse |
| mode | input | 2 | 00 stride-1, 01 skewed, 10 scrambled, 11 reserved |
| count | input | CW | Number of elements in the run |
| ord_valid | input | 1 | Order entry offered |
| ord_ready | output | 1 | Order FIFO can accept an entry |
| ord_data | input | M | One-hot select entry |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | W | Selected buffer word |
| done | output | 1 | Run finished |
| err | output | 1 | A non-one-hot order entry was consumed |

## Verification
The riskiest overlap is a push into the order FIFO in the same cycle that a scrambled-mode element is consumed. The bench provokes it by holding `out_ready` low with one entry queued, then raising `out_ready` and `ord_valid` together. It judges the result by checking that the next element comes from the newly pushed entry, with `out_valid` still high, and that `ord_ready` is high afterwards. A start pulse that arrives while a run is active is a second overlap. The bench checks that the running order continues without change.

// File: rtl/ad_align_pkg.sv
package ad_align_pkg;
  typedef enum logic [1:0] {
    AM_STRIDE   = 2'b00,
    AM_SKEW     = 2'b01,
    AM_SCRAMBLE = 2'b10,
    AM_RSVD     = 2'b11
  } amode_e;
endpackage

// File: rtl/ad_selgen.sv
// One-hot select generator for the stride-1 and skewed orders.
module ad_selgen #(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         skew,
  input  logic         step,
  output logic [M-1:0] sel
);
  localparam int CB = (M > 1) ? $clog2(M) : 1;
  localparam logic [CB-1:0] LAST = CB'(M - 1);
  localparam logic [M-1:0] FIRST = M'(1);

  logic [M-1:0]  row_q;   // outer loop: row starting buffer
  logic [M-1:0]  col_q;   // inner loop: current buffer
  logic [CB-1:0] idx_q;

  function automatic logic [M-1:0] rotl(input logic [M-1:0] v);
    return {v[M-2:0], v[M-1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= FIRST;
      col_q <= FIRST;
      idx_q <= '0;
    end else if (init) begin
      row_q <= FIRST;
      col_q <= FIRST;
      idx_q <= '0;
    end else if (step) begin
      if (skew && idx_q == LAST) begin
        row_q <= rotl(row_q);
        col_q <= rotl(row_q);
        idx_q <= '0;
      end else begin
        col_q <= rotl(col_q);
        idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign sel = col_q;
endmodule

// File: rtl/ad_orderfifo.sv
// FIFO of precomputed select words for the scrambled order.
module ad_orderfifo #(
  parameter int M     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_data,
  input  logic         pop,
  output logic [M-1:0] head,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULLC = (AW + 1)'(DEPTH);

  logic [M-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push, do_pop;

  assign in_ready = (cnt != FULLC);
  assign empty    = (cnt == '0);
  assign push     = in_valid && in_ready;
  assign do_pop   = pop && !empty;
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)   wp <= (wp == PLAST) ? '0 : wp + 1'b1;
      if (do_pop) rp <= (rp == PLAST) ? '0 : rp + 1'b1;
      case ({push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ad_bufset.sv
// Serial-in word buffers and the one-hot output selector.
module ad_bufset #(
  parameter int M = 8,
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [M-1:0] ser_in,
  input  logic [M-1:0] sel,
  output logic [W-1:0] word
);
  logic [W-1:0] words [M];

  for (genvar i = 0; i < M; i++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     words[i] <= '0;
      else if (shift) words[i] <= {words[i][W-2:0], ser_in[i]};
    end
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < M; i++) word = word | (words[i] & {W{sel[i]}});
  end
endmodule

// File: rtl/ad_align_net.sv
module ad_align_net
  import ad_align_pkg::*;
#(
  parameter int M     = 8,
  parameter int W     = 64,
  parameter int DEPTH = 4,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_shift,
  input  logic [M-1:0]  ser_in,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] count,
  input  logic          ord_valid,
  output logic          ord_ready,
  input  logic [M-1:0]  ord_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          done,
  output logic          err
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          busy;
  amode_e        mode_q;
  logic [CW-1:0] remain;
  logic [M-1:0]  head, gen_sel, sel_eff;
  logic          fifo_empty, head_ok, scr, fire, pop, start_ok;

  assign scr      = (mode_q == AM_SCRAMBLE);
  assign start_ok = start && !busy && (mode != 2'b11) && (count != '0);
  assign head_ok  = $onehot(head);
  assign sel_eff  = scr ? (head_ok ? head : '0) : gen_sel;
  assign out_valid = busy && (!scr || !fifo_empty);
  assign fire     = out_valid && out_ready;
  assign pop      = fire && scr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= AM_STRIDE;
      remain <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else if (start_ok) begin
      busy   <= 1'b1;
      mode_q <= amode_e'(mode);
      remain <= count;
      done   <= 1'b0;
      err    <= 1'b0;
    end else if (fire) begin
      remain <= remain - 1'b1;
      if (remain == ONE) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      if (pop && !head_ok) err <= 1'b1;
    end
  end

  ad_selgen #(.M(M)) u_gen (
    .clk  (clk),
    .rst_n(rst_n),
    .init (start_ok),
    .skew (mode_q == AM_SKEW),
    .step (fire && !scr),
    .sel  (gen_sel)
  );

  ad_orderfifo #(.M(M), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(ord_valid),
    .in_ready(ord_ready),
    .in_data (ord_data),
    .pop     (pop),
    .head    (head),
    .empty   (fifo_empty)
  );

  ad_bufset #(.M(M), .W(W)) u_bufs (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (ser_shift),
    .ser_in(ser_in),
    .sel   (sel_eff),
    .word  (out_data)
  );
endmodule

// File: rtl/ad_align_chk.sv
module ad_align_chk #(
  parameter int M  = 8,
  parameter int W  = 64,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_shift,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic          done,
  input logic          err,
  input logic [M-1:0]  sel_eff,
  input logic [1:0]    mode_q,
  input logic [CW-1:0] remain
);
  logic [M-1:0] rot;
  assign rot = {sel_eff[M-2:0], sel_eff[M-1]};

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !ser_shift) |=> (out_valid && $stable(out_data)));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(out_valid && out_ready && mode_q == 2'b10));

  // R4
  stride_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && mode_q == 2'b00 && remain > 1) |=> (sel_eff == $past(rot)));

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_eff));
endmodule

bind ad_align_net ad_align_chk #(.M(M), .W(W), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_shift(ser_shift),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .done     (done),
  .err      (err),
  .sel_eff  (sel_eff),
  .mode_q   (mode_q),
  .remain   (remain)
);

// File: tb/sim_ad_align_net.sv
module sim_ad_align_net;
  localparam int CLK_P = 10;
  localparam int M = 8;
  localparam int W = 64;
  localparam int DEPTH = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ser_shift = 1'b0;
  logic [M-1:0]  ser_in = '0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [CW-1:0] count = '0;
  logic          ord_valid = 1'b0;
  logic          ord_ready;
  logic [M-1:0]  ord_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_data;
  logic          done, err;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ad_align_net #(.M(M), .W(W), .DEPTH(DEPTH), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_shift(ser_shift), .ser_in(ser_in),
    .start(start), .mode(mode), .count(count),
    .ord_valid(ord_valid), .ord_ready(ord_ready), .ord_data(ord_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .err(err)
  );

  function automatic logic [W-1:0] val(int i);
    return {32'hC0DE_0000 | 32'(i), 32'h5A5A_0000 + 32'(i) * 32'h111};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_buffers();
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      ser_shift = 1'b1;
      for (int i = 0; i < M; i++) ser_in[i] = val(i)[W-1-k];
    end
    @(negedge clk);
    ser_shift = 1'b0;
  endtask

  task automatic push(input logic [M-1:0] e);
    @(negedge clk);
    ord_valid = 1'b1;
    ord_data  = e;
    @(negedge clk);
    ord_valid = 1'b0;
  endtask

  task automatic run_start(input logic [1:0] md, input int n);
    @(negedge clk);
    start = 1'b1;
    mode  = md;
    count = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  // at a negedge with out_ready high: check the current element, then let it go
  task automatic consume(input logic [W-1:0] exp, input string tag);
    chk(out_valid === 1'b1, {tag, " valid"}, W'(out_valid), W'(1));
    chk(out_data === exp, tag, out_data, exp);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R1 out_valid", W'(out_valid), 0);
    chk(done === 1'b0, "R1 done", W'(done), 0);
    chk(err === 1'b0, "R1 err", W'(err), 0);
    chk(ord_ready === 1'b1, "R1 ord_ready", W'(ord_ready), W'(1));
  endtask

  task automatic t_stride();
    run_start(2'b00, 10);
    for (int k = 0; k < 10; k++) consume(val(k % M), "R4 R2 stride");
    chk(done === 1'b1, "R11 done", W'(done), W'(1));
    chk(out_valid === 1'b0, "R11 idle", W'(out_valid), 0);
  endtask

  task automatic t_skew();
    run_start(2'b01, 16);
    for (int k = 0; k < 16; k++) consume(val((k / M + k % M) % M), "R5 skew");
    chk(done === 1'b1, "R11 skew done", W'(done), W'(1));
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    run_start(2'b00, 3);
    for (int k = 0; k < 3; k++) begin
      chk(out_valid === 1'b1 && out_data === val(0), "R7 hold", out_data, val(0));
      @(negedge clk);
    end
    out_ready = 1'b1;
    for (int k = 0; k < 3; k++) consume(val(k), "R7 resume");
  endtask

  task automatic t_ignore();
    out_ready = 1'b0;
    run_start(2'b00, 4);
    run_start(2'b01, 2);   // busy: must be ignored
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) consume(val(k), "R3 busy start");
    chk(done === 1'b1, "R3 done", W'(done), W'(1));
    run_start(2'b11, 5);
    chk(out_valid === 1'b0, "R3 reserved mode", W'(out_valid), 0);
    chk(done === 1'b1, "R3 reserved done", W'(done), W'(1));
    run_start(2'b00, 0);
    chk(out_valid === 1'b0, "R3 zero count", W'(out_valid), 0);
    chk(done === 1'b1, "R3 zero done", W'(done), W'(1));
  endtask

  task automatic t_scramble();
    push(8'b0010_0000);
    push(8'b0000_0100);
    push(8'b0000_0011);
    push(8'b1000_0000);
    chk(ord_ready === 1'b0, "R9 full", W'(ord_ready), 0);
    run_start(2'b10, 4);
    consume(val(5), "R6 scr0");
    consume(val(2), "R6 scr1");
    consume('0, "R10 bad entry");
    chk(err === 1'b1, "R10 err", W'(err), W'(1));
    consume(val(7), "R6 scr3");
    chk(done === 1'b1 && err === 1'b1, "R10 err held", W'(err), W'(1));
  endtask

  task automatic t_stall_and_overlap();
    run_start(2'b10, 3);
    chk(err === 1'b0, "R10 err cleared", W'(err), 0);
    chk(out_valid === 1'b0, "R8 stall", W'(out_valid), 0);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 stall2", W'(out_valid), 0);
    push(8'b0000_1000);
    consume(val(3), "R8 resume");
    out_ready = 1'b0;
    push(8'b0000_0010);
    chk(out_valid === 1'b1 && out_data === val(1), "R9 queued", out_data, val(1));
    ord_valid = 1'b1;
    ord_data  = 8'b0100_0000;
    out_ready = 1'b1;
    @(negedge clk);
    ord_valid = 1'b0;
    chk(ord_ready === 1'b1, "R9 push+pop ready", W'(ord_ready), W'(1));
    consume(val(6), "R9 push+pop");
    chk(done === 1'b1, "R11 scr done", W'(done), W'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_buffers();
    t_stride();
    t_skew();
    t_backpressure();
    t_ignore();
    t_scramble();
    t_stall_and_overlap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule